// File: doc/BRIEF.md
# VID-Referenced Voltage Window Monitor

The block turns a 4-bit voltage identification code into a reference level in millivolts. It then judges each digitized output-voltage sample against a window built from fixed ratios of that reference. The lower edge of the window sets an under-voltage flag with hysteresis, and a power-good stage elsewhere uses that flag. The upper edge sets an over-voltage flag. That flag falls back only when the voltage drops a little below the trip point, and a one-cycle strobe marks the release.

The block latches no fault. A downstream sequencer decides what a flag means for the converter. Samples arrive as unsigned millivolt values together with a valid strobe. All thresholds are integer products of the reference with ratios in hundredths, truncated toward zero.

Top module: `vid_window_mon`

## Requirements
- R1: The reference is 2050 mV minus 50 mV times the unsigned code on `vid_i`, so code 15 gives 1300 mV and code 0 gives 2050 mV. Every threshold follows the code: the under-voltage set and clear levels and the over-voltage set and release levels are floor(ref*90/100), floor(ref*92/100), floor(ref*115/100) and floor(ref*113/100).
- R2: When `uv_o` is low, a valid sample strictly below floor(ref*90/100) sets `uv_o`. A sample equal to that level leaves it low.
- R3: When `uv_o` is high, it clears only on a valid sample strictly above floor(ref*92/100). A sample equal to that level, or any sample in between the two levels, leaves it high.
- R4: When `ov_o` is low, a valid sample strictly above floor(ref*115/100) sets `ov_o`. A sample equal to that level leaves it low.
- R5: When `ov_o` is high, it clears only on a valid sample strictly below floor(ref*113/100). Samples from that level up keep it high.
- R6: `ov_clr_o` is high for exactly the one cycle after the valid sample that cleared `ov_o`, and is low at all other times.
- R7: When `smp_valid_i` is low, the flags do not change, whatever value `smp_mv_i` holds.
- R8: A new code on `vid_i` takes effect one cycle after it is applied. A sample presented in the same cycle as the code change is judged against the previous reference.
- R9: After reset, `uv_o` is 1, `ov_o` is 0 and `ov_clr_o` is 0.
- R10: The under-voltage and over-voltage flags act independently and are never latched. A single sample can change both flags, and `ov_o` clears without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_i | input | 4 | Voltage identification code |
| smp_valid_i | input | 1 | Sample strobe |
| smp_mv_i | input | 12 | Output-voltage sample, unsigned mV |
| uv_o | output | 1 | Under-voltage flag |
| ov_o | output | 1 | Over-voltage flag |
| ov_clr_o | output | 1 | One-cycle strobe when over-voltage releases |

## Verification
The assertions check on every cycle that both flags hold while no sample is valid. They check that the release strobe appears only on a falling over-voltage flag and lasts one cycle. They also check that a sample outside the window for every possible code sets the right flag. The exact threshold values for a given code can only be shown by the bench scenarios: the equal-to-threshold boundaries, the hysteresis band held in each direction, and the one-cycle lag between a code change and its reference.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  localparam int unsigned RATIO_DEN = 100;
  localparam int unsigned N_THR     = 4;

  typedef enum int unsigned {
    THR_UV_SET = 0,
    THR_UV_CLR = 1,
    THR_OV_SET = 2,
    THR_OV_CLR = 3
  } thr_sel_e;

  // ratios in hundredths of the reference
  function automatic int unsigned thr_ratio(input int unsigned idx);
    case (idx)
      THR_UV_SET: return 90;
      THR_UV_CLR: return 92;
      THR_OV_SET: return 115;
      default:    return 113;
    endcase
  endfunction
endpackage

// File: rtl/vwm_ref_decode.sv
module vwm_ref_decode #(
  parameter int unsigned VID_W   = 4,
  parameter int unsigned MV_W    = 12,
  parameter int unsigned TOP_MV  = 2050,
  parameter int unsigned STEP_MV = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] vid_i,
  output logic [MV_W-1:0]  ref_mv_o
);
  logic [MV_W-1:0] ref_d, ref_q;

  assign ref_d = MV_W'(TOP_MV) - MV_W'(STEP_MV) * MV_W'(vid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= MV_W'(TOP_MV);
    else         ref_q <= ref_d;
  end

  assign ref_mv_o = ref_q;
endmodule

// File: rtl/vwm_thresholds.sv
module vwm_thresholds
  import vwm_pkg::*;
#(
  parameter int unsigned MV_W = 12
) (
  input  logic [MV_W-1:0]             ref_mv_i,
  output logic [N_THR-1:0][MV_W-1:0]  thr_o
);
  localparam int unsigned PROD_W = MV_W + 8;

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    localparam int unsigned K = thr_ratio(g);
    logic [PROD_W-1:0] prod, quot;
    assign prod     = PROD_W'(ref_mv_i) * PROD_W'(K);
    assign quot     = prod / PROD_W'(RATIO_DEN);
    assign thr_o[g] = quot[MV_W-1:0];
  end
endmodule

// File: rtl/vwm_hyst_cmp.sv
module vwm_hyst_cmp #(
  parameter int unsigned MV_W     = 12,
  parameter bit          SET_HIGH = 1'b1,
  parameter bit          RST_VAL  = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [MV_W-1:0] smp_i,
  input  logic [MV_W-1:0] set_thr_i,
  input  logic [MV_W-1:0] clr_thr_i,
  output logic            flag_o,
  output logic            clr_pulse_o
);
  logic set_hit, clr_hit;
  logic flag_q, pulse_q;

  if (SET_HIGH) begin : g_high
    assign set_hit = smp_i > set_thr_i;
    assign clr_hit = smp_i < clr_thr_i;
  end else begin : g_low
    assign set_hit = smp_i < set_thr_i;
    assign clr_hit = smp_i > clr_thr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= RST_VAL;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (valid_i) begin
        if (!flag_q && set_hit) begin
          flag_q <= 1'b1;
        end else if (flag_q && clr_hit) begin
          flag_q  <= 1'b0;
          pulse_q <= 1'b1;
        end
      end
    end
  end

  assign flag_o      = flag_q;
  assign clr_pulse_o = pulse_q;
endmodule

// File: rtl/vid_window_mon.sv
module vid_window_mon
  import vwm_pkg::*;
#(
  parameter int unsigned VID_W   = 4,
  parameter int unsigned MV_W    = 12,
  parameter int unsigned TOP_MV  = 2050,
  parameter int unsigned STEP_MV = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VID_W-1:0] vid_i,
  input  logic             smp_valid_i,
  input  logic [MV_W-1:0]  smp_mv_i,
  output logic             uv_o,
  output logic             ov_o,
  output logic             ov_clr_o
);
  logic [MV_W-1:0]            ref_mv;
  logic [N_THR-1:0][MV_W-1:0] thr;
  logic                       uv_clr_pulse;

  vwm_ref_decode #(
    .VID_W(VID_W), .MV_W(MV_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV)
  ) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vid_i   (vid_i),
    .ref_mv_o(ref_mv)
  );

  vwm_thresholds #(.MV_W(MV_W)) u_thr (
    .ref_mv_i(ref_mv),
    .thr_o   (thr)
  );

  vwm_hyst_cmp #(.MV_W(MV_W), .SET_HIGH(1'b0), .RST_VAL(1'b1)) u_uv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (smp_valid_i),
    .smp_i      (smp_mv_i),
    .set_thr_i  (thr[THR_UV_SET]),
    .clr_thr_i  (thr[THR_UV_CLR]),
    .flag_o     (uv_o),
    .clr_pulse_o(uv_clr_pulse)
  );

  vwm_hyst_cmp #(.MV_W(MV_W), .SET_HIGH(1'b1), .RST_VAL(1'b0)) u_ov (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (smp_valid_i),
    .smp_i      (smp_mv_i),
    .set_thr_i  (thr[THR_OV_SET]),
    .clr_thr_i  (thr[THR_OV_CLR]),
    .flag_o     (ov_o),
    .clr_pulse_o(ov_clr_o)
  );
endmodule

// File: rtl/vid_window_mon_chk.sv
module vid_window_mon_chk #(
  parameter int unsigned VID_W   = 4,
  parameter int unsigned MV_W    = 12,
  parameter int unsigned TOP_MV  = 2050,
  parameter int unsigned STEP_MV = 50
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            smp_valid_i,
  input logic [MV_W-1:0] smp_mv_i,
  input logic            uv_o,
  input logic            ov_o,
  input logic            ov_clr_o,
  input logic            uv_rise
);
  // below the lowest under-voltage level / above the highest over-voltage level
  localparam int unsigned UV_FLOOR = (TOP_MV - STEP_MV * ((2 ** VID_W) - 1)) * 90 / 100;
  localparam int unsigned OV_CEIL  = TOP_MV * 115 / 100;

  a_r7_uv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(uv_o));

  a_r7_ov_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> $stable(ov_o));

  a_r6_clr_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_clr_o |-> (!ov_o && $past(ov_o)));

  a_r6_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_clr_o |=> !ov_clr_o);

  a_r4_ov_far_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (smp_mv_i > MV_W'(OV_CEIL))) |=> ov_o);

  a_r2_uv_far_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && (smp_mv_i < MV_W'(UV_FLOOR))) |=> uv_o);

  a_r3_uv_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_rise |-> (!uv_o && $past(uv_o)));
endmodule

bind vid_window_mon vid_window_mon_chk #(
  .VID_W(VID_W), .MV_W(MV_W), .TOP_MV(TOP_MV), .STEP_MV(STEP_MV)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_valid_i(smp_valid_i),
  .smp_mv_i   (smp_mv_i),
  .uv_o       (uv_o),
  .ov_o       (ov_o),
  .ov_clr_o   (ov_clr_o),
  .uv_rise    (uv_clr_pulse)
);

// File: tb/sim_vid_window_mon.sv
module sim_vid_window_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  vid = 4'd15;
  logic        valid = 1'b0;
  logic [11:0] smp = '0;
  logic        uv, ov, clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic  uv;
    logic  ov;
    logic  clr;
    int    mv;
    string tag;
  } exp_t;
  exp_t q[$];

  int m_code = 15;
  bit m_uv = 1'b1;
  bit m_ov = 1'b0;

  always #4 clk = ~clk;

  vid_window_mon u0 (
    .clk_i(clk), .rst_ni(rst_n), .vid_i(vid), .smp_valid_i(valid),
    .smp_mv_i(smp), .uv_o(uv), .ov_o(ov), .ov_clr_o(clr)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one sample, optional code change in the same cycle
  task automatic push(input int mv, input string tag, input int new_code = -1);
    int   r, uv_lo, uv_hi, ov_hi, ov_lo;
    exp_t e;
    r     = 2050 - 50 * m_code;
    uv_lo = r * 90 / 100;
    uv_hi = r * 92 / 100;
    ov_hi = r * 115 / 100;
    ov_lo = r * 113 / 100;
    e.clr = 1'b0;
    if (!m_uv && mv < uv_lo) m_uv = 1'b1;
    else if (m_uv && mv > uv_hi) m_uv = 1'b0;
    if (!m_ov && mv > ov_hi) m_ov = 1'b1;
    else if (m_ov && mv < ov_lo) begin m_ov = 1'b0; e.clr = 1'b1; end
    e.uv = m_uv; e.ov = m_ov; e.mv = mv; e.tag = tag;
    @(negedge clk);
    if (new_code >= 0) vid = new_code[3:0];
    valid = 1'b1;
    smp   = mv[11:0];
    q.push_back(e);
    @(negedge clk);
    valid = 1'b0;
    smp   = '0;
    if (new_code >= 0) m_code = new_code;
  endtask

  task automatic set_code(input int code);
    @(negedge clk);
    vid = code[3:0];
    repeat (2) @(negedge clk);
    m_code = code;
  endtask

  // monitor: compare the result one edge after each valid sample
  initial begin
    forever begin
      @(posedge clk);
      if (valid) begin
        @(negedge clk);
        if (q.size() == 0) begin
          chk("SB", "unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.tag, $sformatf("uv mv=%0d", e.mv), int'(uv), int'(e.uv));
          chk(e.tag, $sformatf("ov mv=%0d", e.mv), int'(ov), int'(e.ov));
          chk(e.tag, $sformatf("clr mv=%0d", e.mv), int'(clr), int'(e.clr));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "uv after reset", int'(uv), 1);
    chk("R9", "ov after reset", int'(ov), 0);
    chk("R9", "clr after reset", int'(clr), 0);
    @(negedge clk);

    // code 15: ref 1300, uv 1170/1196, ov 1495/1469
    push(1300, "R3");
    push(1170, "R2");
    push(1169, "R2");
    push(1196, "R3");
    push(1197, "R3");
    // R7: out-of-range value without strobe
    @(negedge clk); smp = 12'd4000;
    repeat (3) @(negedge clk);
    chk("R7", "uv idle", int'(uv), 0);
    chk("R7", "ov idle", int'(ov), 0);
    smp = 12'd100;
    repeat (2) @(negedge clk);
    chk("R7", "uv idle low", int'(uv), 0);
    smp = '0;
    push(1495, "R4");
    push(1496, "R4");
    push(1470, "R5");
    push(1469, "R5");
    push(1468, "R6");
    @(negedge clk);
    chk("R6", "clr one cycle", int'(clr), 0);
    chk("R6", "ov stays clear", int'(ov), 0);

    // code 6: ref 1750, uv 1575/1610, ov 2012/1977
    set_code(6);
    push(1575, "R1");
    push(1574, "R1");
    push(1610, "R1");
    push(1611, "R1");
    push(2012, "R1");
    push(2013, "R1");
    push(1977, "R1");
    push(1976, "R1");

    // code 0: ref 2050, uv 1845/1886, ov 2357/2316
    set_code(0);
    push(1600, "R10");
    push(2358, "R10");
    push(2316, "R10");
    push(2315, "R10");

    // R8: code change and sample in the same cycle
    set_code(15);
    push(1600, "R8", 0);
    push(1600, "R8");
    @(negedge clk);
    chk("R8", "queue drained", q.size(), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule